// File: doc/BRIEF.md
# Switching-Cycle Type Selector (power / sense / skip)

This block picks the kind of every switching cycle for a flyback controller that regulates from the primary side. Output voltage is held by choosing, cycle by cycle, between a full-energy power pulse and a low-energy sense pulse. The pulse width is not modulated. At each cycle-end strobe the block reads the comparator sample taken late in the OFF interval. That sample says whether the feedback is above the reference. From it the block decides the next cycle's kind and hands the gate timer an on-time target.

A sense pulse lasts a quarter of the most recent measured power on-time, so it carries about a sixteenth of the energy. It still returns a valid output measurement. Under light load, a run of sense cycles with no power cycle in between moves the block into skip mode. In that mode sense cycles are separated by cycles with no pulse at all. The number of empty cycles after each sense (the skip depth) grows while the output stays high. It falls back to zero the moment a sense reading comes back low.

The controller is a four-state machine:
- `ST_PWR` is a power cycle.
- `ST_SNS` is a sense cycle in normal mode.
- `ST_SKP` is an empty cycle.
- `ST_SNS_SK` is a sense cycle inside skip mode.

Its named transitions are:
- *stay-power*: PWR to PWR, reading low.
- *probe*: PWR to SNS, reading high.
- *hold-probe*: SNS to SNS, reading high, streak below the limit.
- *enter-skip*: SNS to SKP, reading high, streak at the limit.
- *drain*: SKP to SKP, skip cycles still left.
- *resample*: SKP to SNS_SK, last skip cycle.
- *deepen*: SNS_SK to SKP, reading high.
- *recover*: SNS or SNS_SK to PWR, reading low.

Top module: `pulse_cycle_selector`

## Requirements
- R1: After reset, `cyc_kind` is power, `ton_target` equals `TON_MAX`, `skip_depth` is 0 and `skip_active` is 0.
- R2: State, `cyc_kind`, `skip_depth` and `skip_active` change only on a clock edge where `cyc_end` is high. The comparator input has no effect while `cyc_end` is low.
- R3: The `cyc_kind` encoding is 2'b00 power, 2'b01 sense and 2'b10 skip. At the end of a power cycle, a high reading selects a sense cycle next and a low reading selects another power cycle.
- R4: The target for a power cycle is `TON_MAX`. The target for a skip cycle is 0. The target for a sense cycle is the `pwr_ton` value captured at the end of the latest power cycle, shifted right by two (floor). `pwr_ton` is captured only at the end of a power cycle.
- R5: In normal mode, a high sense reading gives another sense cycle until `SKIP_ENTRY_N` consecutive high sense readings have occurred since the last power cycle. The last of these enters skip mode with depth 1 and a skip cycle next.
- R6: During skip cycles the comparator is ignored. After exactly `skip_depth` skip cycles, a sense cycle follows.
- R7: A high sense reading in skip mode raises the depth by one, saturating at 15. The following run of skip cycles is as long as the new depth.
- R8: Any low sense reading makes the next cycle a power cycle, clears the depth to 0, leaves skip mode and restarts the high-reading streak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_end | input | 1 | One-clock strobe marking the end of the current switching cycle |
| fb_above | input | 1 | Comparator sample, valid with `cyc_end`: feedback above the reference |
| pwr_ton | input | TON_W | Measured on-time of the power cycle that is ending |
| cyc_kind | output | 2 | Kind of the next/current cycle (00 power, 01 sense, 10 skip) |
| ton_target | output | TON_W | On-time target for the gate timer |
| skip_active | output | 1 | High while in skip mode (skip or skip-mode sense cycles) |
| skip_depth | output | 4 | Current skip depth |

## Verification
On a single strobe edge the block can both capture the measured power on-time and switch to a sense cycle. In that case the sense target must already reflect the value captured in that same edge. The table provokes this with differing `pwr_ton` values on consecutive power cycles, the second ending with a high reading. It then checks the quarter value one edge later, and separately checks that a large `pwr_ton` offered at a sense-cycle end is ignored. The second coincidence is a skip-mode depth increment that also reloads the skip-run length. It is judged by counting the empty cycles between sense cycles as the depth climbs to and past saturation.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        CK_POWER = 2'b00,
        CK_SENSE = 2'b01,
        CK_SKIP  = 2'b10
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_PWR,
        ST_SNS,
        ST_SKP,
        ST_SNS_SK
    } sel_state_e;

    typedef struct packed {
        logic streak_inc;
        logic streak_clr;
        logic enter;
        logic bump;
        logic tick;
        logic depth_clr;
    } skip_cmd_t;

endpackage

// File: rtl/pcs_fsm.sv
module pcs_fsm
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_end,
    input  logic       fb_above,
    input  logic       streak_full,
    input  logic       last_skip,
    output cyc_kind_e  kind,
    output logic       in_skip,
    output skip_cmd_t  cmd
);

    sel_state_e state_q;
    sel_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cmd     = '0;
        if (cyc_end) begin
            unique case (state_q)
                ST_PWR: begin
                    cmd.streak_clr = 1'b1;
                    state_d = fb_above ? ST_SNS : ST_PWR;
                end
                ST_SNS: begin
                    if (!fb_above) begin
                        state_d        = ST_PWR;
                        cmd.depth_clr  = 1'b1;
                        cmd.streak_clr = 1'b1;
                    end else if (streak_full) begin
                        state_d   = ST_SKP;
                        cmd.enter = 1'b1;
                    end else begin
                        state_d        = ST_SNS;
                        cmd.streak_inc = 1'b1;
                    end
                end
                ST_SKP: begin
                    cmd.tick = 1'b1;
                    state_d  = last_skip ? ST_SNS_SK : ST_SKP;
                end
                ST_SNS_SK: begin
                    if (fb_above) begin
                        state_d  = ST_SKP;
                        cmd.bump = 1'b1;
                    end else begin
                        state_d        = ST_PWR;
                        cmd.depth_clr  = 1'b1;
                        cmd.streak_clr = 1'b1;
                    end
                end
                default: state_d = ST_PWR;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PWR:    begin kind = CK_POWER; in_skip = 1'b0; end
            ST_SNS:    begin kind = CK_SENSE; in_skip = 1'b0; end
            ST_SKP:    begin kind = CK_SKIP;  in_skip = 1'b1; end
            ST_SNS_SK: begin kind = CK_SENSE; in_skip = 1'b1; end
            default:   begin kind = CK_POWER; in_skip = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pcs_skip_ctl.sv
module pcs_skip_ctl
    import pcs_pkg::*;
#(
    parameter int DEPTH_W = 4,
    parameter int ENTRY_N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  skip_cmd_t          cmd,
    output logic [DEPTH_W-1:0] depth,
    output logic               streak_full,
    output logic               last_skip
);

    localparam int STREAK_W = $clog2(ENTRY_N + 1);
    localparam logic [STREAK_W-1:0] STREAK_LIM = STREAK_W'(ENTRY_N - 1);
    localparam logic [DEPTH_W-1:0]  DEPTH_MAX  = {DEPTH_W{1'b1}};
    localparam logic [DEPTH_W-1:0]  DEPTH_ONE  = DEPTH_W'(1);

    logic [STREAK_W-1:0] streak_q;
    logic [DEPTH_W-1:0]  depth_q;
    logic [DEPTH_W-1:0]  left_q;
    logic [DEPTH_W-1:0]  depth_up;

    assign depth_up = (depth_q == DEPTH_MAX) ? DEPTH_MAX : depth_q + DEPTH_ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            streak_q <= '0;
        end else if (cmd.streak_clr) begin
            streak_q <= '0;
        end else if (cmd.streak_inc && streak_q < STREAK_LIM) begin
            streak_q <= streak_q + STREAK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            left_q  <= '0;
        end else if (cmd.depth_clr) begin
            depth_q <= '0;
            left_q  <= '0;
        end else if (cmd.enter) begin
            depth_q <= DEPTH_ONE;
            left_q  <= DEPTH_ONE;
        end else if (cmd.bump) begin
            depth_q <= depth_up;
            left_q  <= depth_up;
        end else if (cmd.tick && left_q != '0) begin
            left_q  <= left_q - DEPTH_ONE;
        end
    end

    assign depth       = depth_q;
    assign streak_full = (streak_q >= STREAK_LIM);
    assign last_skip   = (left_q <= DEPTH_ONE);

endmodule

// File: rtl/pcs_ton_store.sv
module pcs_ton_store
    import pcs_pkg::*;
#(
    parameter int TON_W       = 10,
    parameter int TON_MAX     = 500,
    parameter int SENSE_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_end,
    input  cyc_kind_e        kind,
    input  logic [TON_W-1:0] pwr_ton,
    output logic [TON_W-1:0] ton_target
);

    localparam logic [TON_W-1:0] TON_CAP = TON_W'(TON_MAX);

    logic [TON_W-1:0] last_ton_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             last_ton_q <= '0;
        else if (cyc_end && kind == CK_POWER)   last_ton_q <= pwr_ton;
    end

    always_comb begin
        unique case (kind)
            CK_POWER: ton_target = TON_CAP;
            CK_SENSE: ton_target = last_ton_q >> SENSE_SHIFT;
            CK_SKIP:  ton_target = '0;
            default:  ton_target = '0;
        endcase
    end

endmodule

// File: rtl/pulse_cycle_selector.sv
module pulse_cycle_selector
    import pcs_pkg::*;
#(
    parameter int TON_W        = 10,
    parameter int TON_MAX      = 500,
    parameter int SKIP_ENTRY_N = 8,
    parameter int DEPTH_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_end,
    input  logic               fb_above,
    input  logic [TON_W-1:0]   pwr_ton,
    output logic [1:0]         cyc_kind,
    output logic [TON_W-1:0]   ton_target,
    output logic               skip_active,
    output logic [DEPTH_W-1:0] skip_depth
);

    cyc_kind_e kind;
    skip_cmd_t cmd;
    logic      streak_full;
    logic      last_skip;

    pcs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_end     (cyc_end),
        .fb_above    (fb_above),
        .streak_full (streak_full),
        .last_skip   (last_skip),
        .kind        (kind),
        .in_skip     (skip_active),
        .cmd         (cmd)
    );

    pcs_skip_ctl #(
        .DEPTH_W (DEPTH_W),
        .ENTRY_N (SKIP_ENTRY_N)
    ) u_skip (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .depth       (skip_depth),
        .streak_full (streak_full),
        .last_skip   (last_skip)
    );

    pcs_ton_store #(
        .TON_W   (TON_W),
        .TON_MAX (TON_MAX)
    ) u_ton (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_end    (cyc_end),
        .kind       (kind),
        .pwr_ton    (pwr_ton),
        .ton_target (ton_target)
    );

    assign cyc_kind = kind;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
#(
    parameter int TON_W   = 10,
    parameter int DEPTH_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_end,
    input logic               fb_above,
    input logic [1:0]         cyc_kind,
    input logic [TON_W-1:0]   ton_target,
    input logic               skip_active,
    input logic [DEPTH_W-1:0] skip_depth
);

    localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

    // R2
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(cyc_kind) && $stable(skip_depth) && $stable(skip_active));

    // R3
    power_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && cyc_kind == CK_POWER) |=>
            cyc_kind == ($past(fb_above) ? 2'(CK_SENSE) : 2'(CK_POWER)));

    // R4
    skip_zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CK_SKIP) |-> ton_target == '0);

    // R5
    skip_entry_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_active) |-> (skip_depth == DEPTH_W'(1)) && (cyc_kind == CK_SKIP));

    // R7
    depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && cyc_kind == CK_SENSE && skip_active && fb_above) |=>
            skip_depth == (($past(skip_depth) == DMAX) ? DMAX : $past(skip_depth) + DEPTH_W'(1)));

    // R8
    low_reading_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && cyc_kind == CK_SENSE && !fb_above) |=>
            cyc_kind == CK_POWER && skip_depth == '0 && !skip_active);

endmodule

bind pulse_cycle_selector pcs_checker #(
    .TON_W   (TON_W),
    .DEPTH_W (DEPTH_W)
) u_pcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_end     (cyc_end),
    .fb_above    (fb_above),
    .cyc_kind    (cyc_kind),
    .ton_target  (ton_target),
    .skip_active (skip_active),
    .skip_depth  (skip_depth)
);

// File: tb/pulse_cycle_selector_test.sv
`timescale 1ns/1ps
module pulse_cycle_selector_test;

    localparam int TW = 10;
    localparam int NROW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_end = 1'b0;
    logic          fb_above = 1'b0;
    logic [TW-1:0] pwr_ton = '0;
    logic [1:0]    cyc_kind;
    logic [TW-1:0] ton_target;
    logic          skip_active;
    logic [3:0]    skip_depth;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pulse_cycle_selector #(.TON_W(TW), .TON_MAX(500), .SKIP_ENTRY_N(3)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .fb_above(fb_above),
        .pwr_ton(pwr_ton), .cyc_kind(cyc_kind), .ton_target(ton_target),
        .skip_active(skip_active), .skip_depth(skip_depth)
    );

    // row: fb, ton, exp kind, exp target, exp depth, exp skip_active
    localparam logic [27:0] TBL [0:NROW-1] = '{
        {1'b0, 10'd200, 2'd0, 10'd500, 4'd0, 1'b0},  // R3 stay power
        {1'b0, 10'd240, 2'd0, 10'd500, 4'd0, 1'b0},  // R3
        {1'b1, 10'd320, 2'd1, 10'd80,  4'd0, 1'b0},  // R3 R4 capture+probe same edge
        {1'b1, 10'd999, 2'd1, 10'd80,  4'd0, 1'b0},  // R4 ton ignored on sense, R5
        {1'b0, 10'd0,   2'd0, 10'd500, 4'd0, 1'b0},  // R8 recover
        {1'b1, 10'd102, 2'd1, 10'd25,  4'd0, 1'b0},  // R4 floor
        {1'b1, 10'd0,   2'd1, 10'd25,  4'd0, 1'b0},  // R5 streak 1
        {1'b1, 10'd0,   2'd1, 10'd25,  4'd0, 1'b0},  // R5 streak 2
        {1'b1, 10'd0,   2'd2, 10'd0,   4'd1, 1'b1},  // R5 enter skip
        {1'b0, 10'd0,   2'd1, 10'd25,  4'd1, 1'b1},  // R6 fb ignored, resample
        {1'b1, 10'd0,   2'd2, 10'd0,   4'd2, 1'b1},  // R7 deepen
        {1'b0, 10'd0,   2'd2, 10'd0,   4'd2, 1'b1},  // R6
        {1'b1, 10'd0,   2'd1, 10'd25,  4'd2, 1'b1},  // R6
        {1'b1, 10'd0,   2'd2, 10'd0,   4'd3, 1'b1},  // R7
        {1'b1, 10'd0,   2'd2, 10'd0,   4'd3, 1'b1},  // R6
        {1'b0, 10'd0,   2'd2, 10'd0,   4'd3, 1'b1},  // R6
        {1'b1, 10'd0,   2'd1, 10'd25,  4'd3, 1'b1},  // R6
        {1'b0, 10'd0,   2'd0, 10'd500, 4'd0, 1'b0},  // R8
        {1'b0, 10'd60,  2'd0, 10'd500, 4'd0, 1'b0}   // R3
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic [TW-1:0] t);
        @(negedge clk);
        fb_above = f;
        pwr_ton  = t;
        cyc_end  = 1'b1;
        @(negedge clk);
        cyc_end  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int prev_d;
        int exp_d;
        int bumps;
        int run;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 kind", cyc_kind, 0);
        check("R1 target", ton_target, 500);
        check("R1 depth", skip_depth, 0);
        check("R1 skip_active", skip_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 kind after release", cyc_kind, 0);

        for (int i = 0; i < NROW; i++) begin
            step(TBL[i][27], TBL[i][26:17]);
            check($sformatf("row %0d kind (R3 R5 R6 R8)", i), cyc_kind, int'(TBL[i][16:15]));
            check($sformatf("row %0d target (R4)", i), ton_target, int'(TBL[i][14:5]));
            check($sformatf("row %0d depth (R7 R8)", i), skip_depth, int'(TBL[i][4:1]));
            check($sformatf("row %0d skip_active (R5 R8)", i), skip_active, int'(TBL[i][0]));
        end

        // enter skip again, then climb depth to saturation (R7, R6 run lengths)
        step(1'b1, 10'd200);
        check("R4 sense target 200>>2", ton_target, 50);
        repeat (3) step(1'b1, 10'd0);
        check("R5 entry kind", cyc_kind, 2);
        check("R5 entry depth", skip_depth, 1);

        // R2: no strobe, comparator toggling, nothing moves
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            fb_above = k[0];
        end
        @(negedge clk);
        check("R2 hold kind", cyc_kind, 2);
        check("R2 hold depth", skip_depth, 1);
        check("R2 hold skip_active", skip_active, 1);

        bumps = 0;
        exp_d = 1;
        while (bumps < 16) begin
            run = 0;
            while (cyc_kind == 2'd2 && run < 40) begin
                step(run[0], 10'd0);
                run++;
            end
            check("R6 skip run length", run, exp_d);
            check("R6 sense after run", cyc_kind, 1);
            prev_d = skip_depth;
            step(1'b1, 10'd0);
            exp_d = (prev_d == 15) ? 15 : prev_d + 1;
            check("R7 depth step", skip_depth, exp_d);
            bumps++;
        end
        check("R7 saturated", skip_depth, 15);

        run = 0;
        while (cyc_kind == 2'd2 && run < 40) begin
            step(1'b0, 10'd0);
            run++;
        end
        step(1'b0, 10'd0);
        check("R8 kind", cyc_kind, 0);
        check("R8 depth", skip_depth, 0);
        check("R8 skip_active", skip_active, 0);

        // R8 streak restarted: two highs stay sense, third enters skip
        step(1'b1, 10'd40);
        step(1'b1, 10'd0);
        step(1'b1, 10'd0);
        check("R8 streak restart kind", cyc_kind, 1);
        check("R4 sense target 40>>2", ton_target, 10);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset kind", cyc_kind, 0);
        check("R1 reset target", ton_target, 500);
        check("R1 reset depth", skip_depth, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule